// File: doc/BRIEF.md
# AUX Transaction Retry Controller

This block sits above a single-transaction AUX channel engine. For each accepted request it issues one or more transaction attempts. It reads the channel outcome and the reply code that the engine returns for each attempt. From these it decides whether to finish with a pass, finish with a fail, reissue at once, or wait a number of microseconds and then reissue.

Each class of trouble has its own counter and its own limit. The classes are:
- short reads answered with ACK
- link-level defers
- I2C stalls
- invalid replies
- timeouts

Some outcomes also clear other counters, and every attempt also counts toward a global cap.

The engine is driven through a one-cycle start pulse that carries the latched request direction and length. It answers with a one-cycle result strobe. Waits are timed from a one-microsecond tick input. The final verdict appears as a one-cycle done pulse together with a pass flag.

Top module: `aux_retry_ctrl`

## Requirements
- R1: After reset, busy, eng_start, done and pass are all low, and no attempt is issued while busy is low.
- R2: A request accepted while idle raises eng_start in the next cycle with eng_write and eng_len equal to the request. busy stays high until the verdict. The verdict is a done pulse lasting exactly one cycle, with busy low in that cycle.
- R3: Outcome OK (0) with reply ACK (code 0) passes. This holds for a write whatever the returned byte count, and for a read whose returned count equals the requested length.
- R4: A read answered with ACK whose returned count differs from the requested length increments the short-read counter. It fails when that counter reaches 7. Otherwise the next attempt starts exactly SHORT_WAIT_US ticks later (default 300).
- R5: Reply codes 2 (link defer), 3 (I2C NACK) and 4 (I2C busy) share one defer counter. They are retried in the cycle after the result, and they fail when that counter reaches 7.
- R6: Reply code 5 (I2C stall) clears the defer counter and increments its own stall counter. It is retried at once, and it fails when the stall counter reaches 7.
- R7: Reply code 1 (NACK), reply code 6 (unplugged) and any code from 7 to 15 fail on the first result.
- R8: Outcome INVALID (1) increments the invalid counter. It fails when that counter reaches 2. Otherwise the next attempt starts exactly INVALID_WAIT_US ticks later (default 400).
- R9: Outcome TIMEOUT (2) increments the timeout counter. It is retried in the cycle after the result, and it fails when that counter reaches 3.
- R10: Every result with outcome OK clears both the timeout counter and the invalid counter.
- R11: Outcome LOST (3), which covers a disconnect or an unknown channel state, fails on the first result.
- R12: No request issues more than MAX_ATTEMPTS attempts (default 7). A result that would call for another attempt after the last allowed one ends in fail.
- R13: Accepting a new request clears every counter and the attempt count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken only while idle |
| req_write | input | 1 | 1 for a write request, 0 for a read |
| req_len | input | LEN_W | Requested payload byte count |
| busy | output | 1 | A request is in progress |
| eng_start | output | 1 | One-cycle pulse that starts an engine attempt |
| eng_write | output | 1 | Latched direction forwarded to the engine |
| eng_len | output | LEN_W | Latched length forwarded to the engine |
| eng_done | input | 1 | One-cycle result strobe from the engine |
| eng_outcome | input | 2 | Channel outcome: 0 OK, 1 INVALID, 2 TIMEOUT, 3 LOST |
| eng_reply | input | 4 | Reply code, meaningful with outcome OK |
| eng_bytes | input | LEN_W | Payload bytes returned by the attempt |
| us_tick | input | 1 | One-cycle pulse once per microsecond |
| done | output | 1 | One-cycle verdict pulse |
| pass | output | 1 | Verdict, valid while done is high |

## Verification
The engine model is scripted with a separate response for each attempt. One group of scripts repeats a single response until a limit is hit, which shows where each counter's limit lies and that each class is kept apart from the others. Another group gives a few failures and then an ACK, which shows that the controller really retries. Mixed scripts interleave timeouts or invalid replies with successful defers; only a design that clears those counters on an OK outcome passes them. Another such script runs past the global attempt cap, which tells the cap apart from the per-class limits. The ticks counted between each result and the next start show whether an attempt followed an immediate retry, a short-read wait or an invalid-reply wait.

// File: rtl/aux_retry_pkg.sv
package aux_retry_pkg;

   // channel outcome reported by the single-transaction engine
   localparam logic [1:0] OC_OK      = 2'd0;
   localparam logic [1:0] OC_INVALID = 2'd1;
   localparam logic [1:0] OC_TIMEOUT = 2'd2;
   localparam logic [1:0] OC_LOST    = 2'd3;

   // reply codes, meaningful only with OC_OK
   localparam logic [3:0] RPL_ACK       = 4'd0;
   localparam logic [3:0] RPL_NACK      = 4'd1;
   localparam logic [3:0] RPL_DEFER     = 4'd2;
   localparam logic [3:0] RPL_I2C_NACK  = 4'd3;
   localparam logic [3:0] RPL_I2C_BUSY  = 4'd4;
   localparam logic [3:0] RPL_I2C_STALL = 4'd5;
   localparam logic [3:0] RPL_UNPLUG    = 4'd6;

   // retry-class indices into the counter bank
   localparam int CLS_SHORT   = 0;
   localparam int CLS_DEFER   = 1;
   localparam int CLS_STALL   = 2;
   localparam int CLS_INVALID = 3;
   localparam int CLS_TIMEOUT = 4;
   localparam int NUM_CLS     = 5;

   typedef enum logic [1:0] {
      ACT_PASS  = 2'd0,
      ACT_FAIL  = 2'd1,
      ACT_RETRY = 2'd2,
      ACT_WAIT  = 2'd3
   } action_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_PEND  = 2'd2,
      ST_DELAY = 2'd3
   } state_e;

   function automatic int max2(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/aux_retry_tally.sv
module aux_retry_tally #(
   parameter int W = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clr,
   input  logic         inc,
   output logic [W-1:0] count
);

   localparam logic [W-1:0] TOP = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         count <= '0;
      end else if (clr) begin
         count <= '0;
      end else if (inc && (count != TOP)) begin
         count <= count + 1'b1;
      end
   end

endmodule

// File: rtl/aux_retry_delay.sv
module aux_retry_delay #(
   parameter int W = 9
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] target,
   input  logic         tick,
   output logic         expire
);

   logic [W-1:0] ticks;
   logic [W-1:0] goal;
   logic         armed;

   assign expire = armed && tick && (ticks == goal - 1'b1);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ticks <= '0;
         goal  <= '0;
         armed <= 1'b0;
      end else if (load) begin
         ticks <= '0;
         goal  <= target;
         armed <= 1'b1;
      end else if (expire) begin
         armed <= 1'b0;
         ticks <= '0;
      end else if (armed && tick) begin
         ticks <= ticks + 1'b1;
      end
   end

endmodule

// File: rtl/aux_retry_policy.sv
module aux_retry_policy
   import aux_retry_pkg::*;
#(
   parameter int LEN_W         = 5,
   parameter int CNT_W         = 3,
   parameter int SHORT_LIMIT   = 7,
   parameter int DEFER_LIMIT   = 7,
   parameter int STALL_LIMIT   = 7,
   parameter int INVALID_LIMIT = 2,
   parameter int TIMEOUT_LIMIT = 3
) (
   input  logic [1:0]                      outcome,
   input  logic [3:0]                      reply,
   input  logic [LEN_W-1:0]                bytes,
   input  logic                            is_write,
   input  logic [LEN_W-1:0]                want_len,
   input  logic [NUM_CLS-1:0][CNT_W-1:0]   counts,
   output action_e                         action,
   output logic                            long_wait,
   output logic [NUM_CLS-1:0]              inc_vec,
   output logic [NUM_CLS-1:0]              clr_vec
);

   localparam int LIMS [NUM_CLS] = '{SHORT_LIMIT, DEFER_LIMIT, STALL_LIMIT,
                                     INVALID_LIMIT, TIMEOUT_LIMIT};

   logic [NUM_CLS-1:0] at_lim;
   logic               short_rd;

   // a class is exhausted when the increment about to happen reaches its limit
   for (genvar g = 0; g < NUM_CLS; g++) begin : g_lim
      assign at_lim[g] = (int'(counts[g]) + 1) >= LIMS[g];
   end

   assign short_rd = !is_write && (bytes != want_len);

   always_comb begin
      action    = ACT_FAIL;
      long_wait = 1'b0;
      inc_vec   = '0;
      clr_vec   = '0;
      case (outcome)
         OC_OK: begin
            clr_vec[CLS_TIMEOUT] = 1'b1;
            clr_vec[CLS_INVALID] = 1'b1;
            case (reply)
               RPL_ACK: begin
                  if (short_rd) begin
                     inc_vec[CLS_SHORT] = 1'b1;
                     action = at_lim[CLS_SHORT] ? ACT_FAIL : ACT_WAIT;
                  end else begin
                     action = ACT_PASS;
                  end
               end
               RPL_DEFER, RPL_I2C_NACK, RPL_I2C_BUSY: begin
                  inc_vec[CLS_DEFER] = 1'b1;
                  action = at_lim[CLS_DEFER] ? ACT_FAIL : ACT_RETRY;
               end
               RPL_I2C_STALL: begin
                  clr_vec[CLS_DEFER] = 1'b1;
                  inc_vec[CLS_STALL] = 1'b1;
                  action = at_lim[CLS_STALL] ? ACT_FAIL : ACT_RETRY;
               end
               default: action = ACT_FAIL;
            endcase
         end
         OC_INVALID: begin
            inc_vec[CLS_INVALID] = 1'b1;
            long_wait = 1'b1;
            action = at_lim[CLS_INVALID] ? ACT_FAIL : ACT_WAIT;
         end
         OC_TIMEOUT: begin
            inc_vec[CLS_TIMEOUT] = 1'b1;
            action = at_lim[CLS_TIMEOUT] ? ACT_FAIL : ACT_RETRY;
         end
         default: action = ACT_FAIL;
      endcase
   end

endmodule

// File: rtl/aux_retry_ctrl.sv
module aux_retry_ctrl
   import aux_retry_pkg::*;
#(
   parameter int LEN_W           = 5,
   parameter int MAX_ATTEMPTS    = 7,
   parameter int SHORT_LIMIT     = 7,
   parameter int DEFER_LIMIT     = 7,
   parameter int STALL_LIMIT     = 7,
   parameter int INVALID_LIMIT   = 2,
   parameter int TIMEOUT_LIMIT   = 3,
   parameter int SHORT_WAIT_US   = 300,
   parameter int INVALID_WAIT_US = 400
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic             req_write,
   input  logic [LEN_W-1:0] req_len,
   output logic             busy,
   output logic             eng_start,
   output logic             eng_write,
   output logic [LEN_W-1:0] eng_len,
   input  logic             eng_done,
   input  logic [1:0]       eng_outcome,
   input  logic [3:0]       eng_reply,
   input  logic [LEN_W-1:0] eng_bytes,
   input  logic             us_tick,
   output logic             done,
   output logic             pass
);

   localparam int LIM_MAX = max2(max2(max2(SHORT_LIMIT, DEFER_LIMIT), STALL_LIMIT),
                                 max2(INVALID_LIMIT, TIMEOUT_LIMIT));
   localparam int CNT_W   = $clog2(LIM_MAX + 1);
   localparam int ATT_W   = $clog2(MAX_ATTEMPTS + 1);
   localparam int TMR_W   = $clog2(max2(SHORT_WAIT_US, INVALID_WAIT_US) + 1);
   localparam logic [TMR_W-1:0] SHORT_GOAL   = TMR_W'(SHORT_WAIT_US);
   localparam logic [TMR_W-1:0] INVALID_GOAL = TMR_W'(INVALID_WAIT_US);
   localparam logic [ATT_W-1:0] ATT_CAP      = ATT_W'(MAX_ATTEMPTS);

   // elaboration-time parameter checks
   if (LEN_W < 1) begin : g_bad_len
      $error("LEN_W must be at least 1");
   end
   if (MAX_ATTEMPTS < 1) begin : g_bad_att
      $error("MAX_ATTEMPTS must be at least 1");
   end
   if (SHORT_LIMIT < 1 || DEFER_LIMIT < 1 || STALL_LIMIT < 1 ||
       INVALID_LIMIT < 1 || TIMEOUT_LIMIT < 1) begin : g_bad_lim
      $error("every retry limit must be at least 1");
   end
   if (SHORT_WAIT_US < 1 || INVALID_WAIT_US < 1) begin : g_bad_wait
      $error("wait intervals must be at least one tick");
   end

   state_e                     state;
   logic [ATT_W-1:0]           attempts;
   logic                       lat_write;
   logic [LEN_W-1:0]           lat_len;
   logic [NUM_CLS-1:0][CNT_W-1:0] cls_cnt;
   logic [NUM_CLS-1:0]         inc_vec;
   logic [NUM_CLS-1:0]         clr_vec;
   action_e                    action;
   logic                       long_wait;
   logic                       accept;
   logic                       result;
   logic                       cap_hit;
   logic                       go_wait;
   logic                       expire;

   assign accept    = (state == ST_IDLE) && req_valid;
   assign result    = (state == ST_PEND) && eng_done;
   assign cap_hit   = (attempts >= ATT_CAP);
   assign go_wait   = result && (action == ACT_WAIT) && !cap_hit;
   assign busy      = (state != ST_IDLE);
   assign eng_start = (state == ST_ISSUE);
   assign eng_write = lat_write;
   assign eng_len   = lat_len;

   aux_retry_policy #(
      .LEN_W        (LEN_W),
      .CNT_W        (CNT_W),
      .SHORT_LIMIT  (SHORT_LIMIT),
      .DEFER_LIMIT  (DEFER_LIMIT),
      .STALL_LIMIT  (STALL_LIMIT),
      .INVALID_LIMIT(INVALID_LIMIT),
      .TIMEOUT_LIMIT(TIMEOUT_LIMIT)
   ) u_policy (
      .outcome  (eng_outcome),
      .reply    (eng_reply),
      .bytes    (eng_bytes),
      .is_write (lat_write),
      .want_len (lat_len),
      .counts   (cls_cnt),
      .action   (action),
      .long_wait(long_wait),
      .inc_vec  (inc_vec),
      .clr_vec  (clr_vec)
   );

   // one counter per retry class
   for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
      aux_retry_tally #(.W(CNT_W)) u_tally (
         .clk  (clk),
         .rst_n(rst_n),
         .clr  (accept || (result && clr_vec[c])),
         .inc  (result && inc_vec[c]),
         .count(cls_cnt[c])
      );
   end

   aux_retry_delay #(.W(TMR_W)) u_delay (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (go_wait),
      .target(long_wait ? INVALID_GOAL : SHORT_GOAL),
      .tick  (us_tick),
      .expire(expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         attempts  <= '0;
         lat_write <= 1'b0;
         lat_len   <= '0;
         done      <= 1'b0;
         pass      <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (req_valid) begin
                  lat_write <= req_write;
                  lat_len   <= req_len;
                  attempts  <= '0;
                  state     <= ST_ISSUE;
               end
            end
            ST_ISSUE: begin
               attempts <= attempts + 1'b1;
               state    <= ST_PEND;
            end
            ST_PEND: begin
               if (eng_done) begin
                  case (action)
                     ACT_PASS: begin
                        done  <= 1'b1;
                        pass  <= 1'b1;
                        state <= ST_IDLE;
                     end
                     ACT_RETRY, ACT_WAIT: begin
                        if (cap_hit) begin
                           done  <= 1'b1;
                           pass  <= 1'b0;
                           state <= ST_IDLE;
                        end else begin
                           state <= (action == ACT_WAIT) ? ST_DELAY : ST_ISSUE;
                        end
                     end
                     default: begin
                        done  <= 1'b1;
                        pass  <= 1'b0;
                        state <= ST_IDLE;
                     end
                  endcase
               end
            end
            ST_DELAY: begin
               if (expire) begin
                  state <= ST_ISSUE;
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

endmodule

// File: rtl/aux_retry_chk.sv
module aux_retry_chk
   import aux_retry_pkg::*;
#(
   parameter int MAX_ATTEMPTS = 7
) (
   input logic       clk,
   input logic       rst_n,
   input logic       req_valid,
   input logic       busy,
   input logic       eng_start,
   input logic       eng_done,
   input logic [1:0] eng_outcome,
   input logic [3:0] eng_reply,
   input logic       done,
   input logic       pass
);

   localparam int SW = $clog2(MAX_ATTEMPTS + 2);

   logic [SW-1:0] starts_seen;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         starts_seen <= '0;
      end else if (req_valid && !busy) begin
         starts_seen <= '0;
      end else if (eng_start) begin
         starts_seen <= starts_seen + 1'b1;
      end
   end

   // R1: nothing is issued while idle
   p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !eng_start);

   // R2: single-cycle done pulse
   p_done_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   // R2: single-cycle start pulse
   p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      eng_start |=> !eng_start);

   // R2: an accepted request starts an attempt next cycle
   p_start_after_req_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (req_valid && !busy) |=> eng_start);

   // R7: native NACK ends in fail at once
   p_nack_fails_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && eng_done && eng_outcome == OC_OK && eng_reply == RPL_NACK)
      |=> (done && !pass));

   // R9: timeout retries with no added wait, or gives up
   p_timeout_now_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && eng_done && eng_outcome == OC_TIMEOUT)
      |=> (eng_start || (done && !pass)));

   // R11: lost channel ends in fail at once
   p_lost_fails_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && eng_done && eng_outcome == OC_LOST) |=> (done && !pass));

   // R12: attempt cap per request
   p_attempt_cap_r12: assert property (@(posedge clk) disable iff (!rst_n)
      int'(starts_seen) <= MAX_ATTEMPTS);

endmodule

bind aux_retry_ctrl aux_retry_chk #(.MAX_ATTEMPTS(MAX_ATTEMPTS)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .req_valid  (req_valid),
   .busy       (busy),
   .eng_start  (eng_start),
   .eng_done   (eng_done),
   .eng_outcome(eng_outcome),
   .eng_reply  (eng_reply),
   .done       (done),
   .pass       (pass)
);

// File: tb/tb_aux_retry_ctrl.sv
`timescale 1ns/1ps
module tb_aux_retry_ctrl;
   import aux_retry_pkg::*;

   localparam int LEN_W    = 5;
   localparam int TICK_DIV = 5;
   localparam int MAXS     = 16;
   localparam int SW_US    = 300;
   localparam int IW_US    = 400;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             req_valid = 1'b0;
   logic             req_write = 1'b0;
   logic [LEN_W-1:0] req_len = '0;
   logic             eng_done = 1'b0;
   logic [1:0]       eng_outcome = 2'd0;
   logic [3:0]       eng_reply = 4'd0;
   logic [LEN_W-1:0] eng_bytes = '0;
   logic             us_tick = 1'b0;
   logic             busy, eng_start, eng_write, done, pass;
   logic [LEN_W-1:0] eng_len;

   always #2.5 clk = ~clk;

   aux_retry_ctrl dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_len(req_len), .busy(busy), .eng_start(eng_start), .eng_write(eng_write),
      .eng_len(eng_len), .eng_done(eng_done), .eng_outcome(eng_outcome),
      .eng_reply(eng_reply), .eng_bytes(eng_bytes), .us_tick(us_tick),
      .done(done), .pass(pass)
   );

   typedef struct packed {
      logic       wr;
      logic [4:0] len;
      logic [3:0] rep;
      logic [1:0] f_oc;
      logic [3:0] f_rp;
      logic [4:0] f_by;
      logic [1:0] l_oc;
      logic [3:0] l_rp;
      logic [4:0] l_by;
      logic [3:0] e_att;
      logic       e_pass;
      logic [9:0] e_gap;
   } vec_t;

   localparam int NV = 17;
   // wr len rep | first oc rp by | last oc rp by | attempts pass gap
   localparam vec_t VECS [NV] = '{
      '{1'b1,5'd4,4'd0,  2'd0,4'd0,5'd0,  2'd0,4'd0,5'd0,  4'd1,1'b1,10'd0},   // R3 write, bytes ignored
      '{1'b0,5'd4,4'd0,  2'd0,4'd0,5'd0,  2'd0,4'd0,5'd4,  4'd1,1'b1,10'd0},   // R3 full read
      '{1'b0,5'd3,4'd3,  2'd0,4'd2,5'd0,  2'd0,4'd0,5'd3,  4'd4,1'b1,10'd0},   // R5 defer then ACK
      '{1'b1,5'd2,4'd15, 2'd0,4'd3,5'd0,  2'd0,4'd0,5'd0,  4'd7,1'b0,10'd0},   // R5 I2C NACK limit
      '{1'b1,5'd2,4'd15, 2'd0,4'd4,5'd0,  2'd0,4'd0,5'd0,  4'd7,1'b0,10'd0},   // R5 I2C busy limit
      '{1'b0,5'd2,4'd15, 2'd0,4'd5,5'd0,  2'd0,4'd0,5'd0,  4'd7,1'b0,10'd0},   // R6 stall limit
      '{1'b1,5'd1,4'd2,  2'd0,4'd5,5'd0,  2'd0,4'd0,5'd0,  4'd3,1'b1,10'd0},   // R6 stall then ACK
      '{1'b1,5'd1,4'd0,  2'd0,4'd0,5'd0,  2'd0,4'd1,5'd0,  4'd1,1'b0,10'd0},   // R7 NACK
      '{1'b1,5'd1,4'd0,  2'd0,4'd0,5'd0,  2'd0,4'd6,5'd0,  4'd1,1'b0,10'd0},   // R7 unplugged
      '{1'b1,5'd1,4'd0,  2'd0,4'd0,5'd0,  2'd0,4'd11,5'd0, 4'd1,1'b0,10'd0},   // R7 unknown code
      '{1'b1,5'd2,4'd1,  2'd1,4'd0,5'd0,  2'd0,4'd0,5'd0,  4'd2,1'b1,10'd400}, // R8 invalid then ACK
      '{1'b1,5'd2,4'd15, 2'd1,4'd0,5'd0,  2'd0,4'd0,5'd0,  4'd2,1'b0,10'd400}, // R8 invalid limit
      '{1'b1,5'd2,4'd15, 2'd2,4'd0,5'd0,  2'd0,4'd0,5'd0,  4'd3,1'b0,10'd0},   // R9 timeout limit
      '{1'b1,5'd2,4'd2,  2'd2,4'd0,5'd0,  2'd0,4'd0,5'd0,  4'd3,1'b1,10'd0},   // R9 R13 fresh counters
      '{1'b1,5'd2,4'd0,  2'd0,4'd0,5'd0,  2'd3,4'd0,5'd0,  4'd1,1'b0,10'd0},   // R11 lost
      '{1'b0,5'd4,4'd1,  2'd0,4'd0,5'd2,  2'd0,4'd0,5'd4,  4'd2,1'b1,10'd300}, // R4 short then full
      '{1'b0,5'd4,4'd15, 2'd0,4'd0,5'd1,  2'd0,4'd0,5'd0,  4'd7,1'b0,10'd300}  // R4 short limit
   };
   string ROW_TAG [NV] = '{"R3","R3","R5","R5","R5","R6","R6","R7","R7","R7",
                           "R8","R8","R9","R13","R11","R4","R4"};

   int n_checks = 0;
   int n_fail   = 0;

   logic [1:0]       sc_oc [MAXS];
   logic [3:0]       sc_rp [MAXS];
   logic [LEN_W-1:0] sc_by [MAXS];
   int               sc_gap[MAXS];

   int n_att = 0;
   int pend = 0;
   int tickc = 0;
   int gap_err = 0;
   int phase = 0;
   bit waiting = 0;

   task automatic check(input bit ok, input string tag, input string what,
                        input int act, input int exp);
      n_checks++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
      end
   endtask

   // engine model, tick source and gap monitor in one process
   always @(negedge clk) begin
      int idx;
      if (!rst_n) begin
         pend = 0; eng_done = 1'b0; us_tick = 1'b0; phase = 0;
      end else begin
         if (eng_done) begin
            waiting = 1'b1;
            tickc = 0;
         end else if (waiting && us_tick) begin
            tickc++;
         end
         if (eng_start) begin
            if (n_att > 0) begin
               idx = (n_att - 1 < MAXS) ? n_att - 1 : MAXS - 1;
               if (tickc != sc_gap[idx] || (sc_gap[idx] == 0 && !eng_done)) begin
                  gap_err++;
                  $display("note: gap before attempt %0d: %0d ticks, wanted %0d",
                           n_att + 1, tickc, sc_gap[idx]);
               end
            end
            waiting = 1'b0;
            n_att++;
            pend = 2;
         end
         eng_done = 1'b0;
         if (pend > 0) begin
            pend--;
            if (pend == 0) begin
               idx = (n_att - 1 < MAXS) ? n_att - 1 : MAXS - 1;
               eng_done    = 1'b1;
               eng_outcome = sc_oc[idx];
               eng_reply   = sc_rp[idx];
               eng_bytes   = sc_by[idx];
            end
         end
         phase = (phase + 1) % TICK_DIV;
         us_tick = (phase == 0);
      end
   end

   task automatic set_step(input int i, input logic [1:0] oc, input logic [3:0] rp,
                           input logic [LEN_W-1:0] by, input int gap);
      sc_oc[i] = oc; sc_rp[i] = rp; sc_by[i] = by; sc_gap[i] = gap;
   endtask

   task automatic run_case(input string tag, input bit wr, input logic [LEN_W-1:0] len,
                           input int exp_att, input bit exp_pass);
      int w;
      @(negedge clk);
      n_att = 0; gap_err = 0; waiting = 1'b0;
      req_valid = 1'b1; req_write = wr; req_len = len;
      @(negedge clk);
      req_valid = 1'b0;
      check(eng_start === 1'b1, "R2", {tag, " start after request"}, eng_start, 1);
      check(busy === 1'b1, "R2", {tag, " busy after request"}, busy, 1);
      check(eng_write === wr && eng_len === len, "R2", {tag, " forwarded request"},
            {eng_write, eng_len}, {wr, len});
      w = 0;
      while (done !== 1'b1 && w < 40000) begin
         @(negedge clk);
         w++;
      end
      check(done === 1'b1, tag, "verdict reached", done, 1);
      check(pass === exp_pass, tag, "pass flag", pass, exp_pass);
      check(n_att == exp_att, tag, "attempt count", n_att, exp_att);
      check(gap_err == 0, tag, "gap mismatches", gap_err, 0);
      check(busy === 1'b0, "R2", {tag, " busy low at verdict"}, busy, 0);
      @(negedge clk);
      check(done === 1'b0, "R2", {tag, " done width"}, done, 0);
      repeat (3) @(negedge clk);
   endtask

   task automatic summary();
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
   endtask

   initial begin
      #(200000 * 5);
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      vec_t e;
      repeat (4) @(negedge clk);
      // R1 outputs quiet during reset
      check(busy === 1'b0 && eng_start === 1'b0, "R1", "busy/start in reset",
            {busy, eng_start}, 0);
      check(done === 1'b0 && pass === 1'b0, "R1", "done/pass in reset", {done, pass}, 0);
      rst_n = 1'b1;
      repeat (3) @(negedge clk);
      check(busy === 1'b0 && eng_start === 1'b0 && done === 1'b0, "R1",
            "idle after reset", {busy, eng_start, done}, 0);

      for (int v = 0; v < NV; v++) begin
         e = VECS[v];
         for (int i = 0; i < MAXS; i++) begin
            if (i < int'(e.rep)) set_step(i, e.f_oc, e.f_rp, e.f_by, int'(e.e_gap));
            else                 set_step(i, e.l_oc, e.l_rp, e.l_by, int'(e.e_gap));
         end
         run_case(ROW_TAG[v], e.wr, e.len, int'(e.e_att), e.e_pass);
      end

      // R10: defers with outcome OK clear the timeout count: T T D T T ACK passes
      for (int i = 0; i < MAXS; i++) set_step(i, OC_OK, RPL_ACK, 5'd0, 0);
      set_step(0, OC_TIMEOUT, 4'd0, 5'd0, 0);
      set_step(1, OC_TIMEOUT, 4'd0, 5'd0, 0);
      set_step(2, OC_OK, RPL_DEFER, 5'd0, 0);
      set_step(3, OC_TIMEOUT, 4'd0, 5'd0, 0);
      set_step(4, OC_TIMEOUT, 4'd0, 5'd0, 0);
      run_case("R10", 1'b1, 5'd2, 6, 1'b1);

      // R10: the invalid count is cleared too: I D I ACK passes, waits 400/0/400
      for (int i = 0; i < MAXS; i++) set_step(i, OC_OK, RPL_ACK, 5'd0, 0);
      set_step(0, OC_INVALID, 4'd0, 5'd0, IW_US);
      set_step(1, OC_OK, RPL_DEFER, 5'd0, 0);
      set_step(2, OC_INVALID, 4'd0, 5'd0, IW_US);
      run_case("R10", 1'b1, 5'd2, 4, 1'b1);

      // R12: no class limit is hit, yet the seventh result ends the request
      for (int i = 0; i < MAXS; i++) set_step(i, OC_OK, RPL_ACK, 5'd0, 0);
      set_step(0, OC_TIMEOUT, 4'd0, 5'd0, 0);
      set_step(1, OC_TIMEOUT, 4'd0, 5'd0, 0);
      set_step(2, OC_OK, RPL_DEFER, 5'd0, 0);
      set_step(3, OC_TIMEOUT, 4'd0, 5'd0, 0);
      set_step(4, OC_TIMEOUT, 4'd0, 5'd0, 0);
      set_step(5, OC_OK, RPL_DEFER, 5'd0, 0);
      set_step(6, OC_TIMEOUT, 4'd0, 5'd0, 0);
      run_case("R12", 1'b1, 5'd2, 7, 1'b0);

      // R4 with the shorter wait for a read: short once, then full
      for (int i = 0; i < MAXS; i++) set_step(i, OC_OK, RPL_ACK, 5'd6, SW_US);
      set_step(0, OC_OK, RPL_ACK, 5'd0, SW_US);
      run_case("R4", 1'b0, 5'd6, 2, 1'b1);

      summary();
      $finish;
   end

endmodule